// File: doc/BRIEF.md
# Serial Test Port with Boundary Cells

This block is a serial test port that lets an external tester reach a short register of boundary cells placed between a set of functional inputs and the matching functional outputs. A 16-state controller advances on each rising edge of the test clock. The only input that steers it is the mode select line. The controller walks through separate paths for the instruction register and for the data registers. Serial data enters on the rising edge and leaves on the falling edge. An active-low asynchronous reset returns the port to its idle, transparent condition at once.

The active instruction picks the data path between the serial input and the serial output. One choice places the boundary cells in the path and drives the outputs from their update latches. A second choice places the cells in the path but leaves the outputs transparent, so the pins can be sampled without disturbing them. Every other code, including the reset default, places a one-bit bypass stage in the path. Each cell has a capture/shift flop and a separate update latch. Test data can therefore be shifted through the chain while the outputs hold a steady, previously loaded value.

Top module: `scan_port_top`

## Requirements
- R1: While `test_rst_n` is low, the following hold at once, without a clock edge: the controller is in its reset state, the active instruction is all ones (bypass), every update latch is 0, and `ser_out` and `ser_oe` are 0.
- R2: The controller has 16 states and changes state only on a rising edge of `test_clk`, as a function of `mode_sel` alone. Five consecutive rising edges with `mode_sel` high reach the reset state from any state. A data shift left through exit and pause states resumes where it stopped.
- R3: On entering instruction capture, the instruction shift stage loads 1 in bit 0 and 0 in every other bit. During instruction shift it moves toward bit 0, and `ser_in` enters the top bit. The shifted code becomes active on the falling edge in the instruction-update state. The reset state forces the active code to all ones on the next falling edge.
- R4: Active code 0 (drive) selects the boundary cells and puts them in test mode. Code 1 (observe) selects the boundary cells with the outputs transparent. Every other code selects bypass.
- R5: In data capture the bypass stage loads 0. In data shift it loads `ser_in`, so a bypass scan returns a 0 followed by the shifted-in bits, each delayed by one position.
- R6: In data capture, with the boundary cells selected, cell k loads `pin_in[k]`.
- R7: In data shift, with the boundary cells selected, cell NCELLS-1 loads `ser_in` and cell k loads cell k+1. Cell 0 feeds the serial output, so the first captured bit to leave is `pin_in[0]`.
- R8: Update latches load their cell's capture flop only on the falling edge in the data-update state while the boundary cells are selected. Otherwise, bypass scans included, they hold.
- R9: In test mode `pin_out[k]` equals update latch k. In every other case it equals `pin_in[k]`.
- R10: `ser_out` and `ser_oe` change only on falling edges of `test_clk`. In the two shift states `ser_oe` is 1 and `ser_out` is bit 0 of the selected register. In every other state both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| test_clk | input | 1 | Test clock; controller and capture flops on rising edge, update latches and serial output on falling edge |
| test_rst_n | input | 1 | Asynchronous active-low reset of the port |
| mode_sel | input | 1 | Steers the 16-state controller, sampled on the rising edge |
| ser_in | input | 1 | Serial data and instruction input, sampled on the rising edge |
| pin_in | input | NCELLS | Functional inputs seen by the boundary cells |
| ser_out | output | 1 | Serial output, 0 when not shifting |
| ser_oe | output | 1 | High while `ser_out` carries shifted data |
| pin_out | output | NCELLS | Functional outputs, transparent or driven from the update latches |

## Verification
The bench goes after the half-cycle relationships first. A design that moved `ser_out` on the rising edge would show the next bit too early when sampled between the rising and falling edge. A design that updated latches outside the update state, or during bypass scans, would change the pins after a scan that should leave them alone. The bench leaves the shift state through pause and comes back, then leaves shift and instruction-shift with five high mode bits. A controller with a wrong transition would lose a bit, or fail to return the instruction to bypass, which shows as driven pins where transparent ones are expected. An asynchronous reset applied mid-cycle during a drive-mode shift must release the pins and the output enable before any clock edge arrives.

// File: rtl/scan_pkg.sv
// Shared types for the serial test port: controller state encoding and
// its next-state function. Assumes nothing beyond a two-valued mode bit.
package scan_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DSEL, ST_DCAP, ST_DSHF, ST_DEX1, ST_DPAU, ST_DEX2, ST_DUPD,
        ST_ISEL, ST_ICAP, ST_ISHF, ST_IEX1, ST_IPAU, ST_IEX2, ST_IUPD
    } tap_state_e;

    // Next state of the 16-state controller for a given mode bit.
    function automatic tap_state_e next_state(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET: n = m ? ST_RESET : ST_IDLE;
            ST_IDLE:  n = m ? ST_DSEL  : ST_IDLE;
            ST_DSEL:  n = m ? ST_ISEL  : ST_DCAP;
            ST_DCAP:  n = m ? ST_DEX1  : ST_DSHF;
            ST_DSHF:  n = m ? ST_DEX1  : ST_DSHF;
            ST_DEX1:  n = m ? ST_DUPD  : ST_DPAU;
            ST_DPAU:  n = m ? ST_DEX2  : ST_DPAU;
            ST_DEX2:  n = m ? ST_DUPD  : ST_DSHF;
            ST_DUPD:  n = m ? ST_DSEL  : ST_IDLE;
            ST_ISEL:  n = m ? ST_RESET : ST_ICAP;
            ST_ICAP:  n = m ? ST_IEX1  : ST_ISHF;
            ST_ISHF:  n = m ? ST_IEX1  : ST_ISHF;
            ST_IEX1:  n = m ? ST_IUPD  : ST_IPAU;
            ST_IPAU:  n = m ? ST_IEX2  : ST_IPAU;
            ST_IEX2:  n = m ? ST_IUPD  : ST_ISHF;
            default:  n = m ? ST_DSEL  : ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/scan_fsm.sv
// 16-state test controller. Advances on the rising clock edge from the
// mode bit only; asynchronous active-low reset enters ST_RESET at once.
// Emits one-hot style strobes decoded from the current state.
module scan_fsm
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sel,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       shf_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir
);

    // State register, stepped by the mode bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= next_state(state, mode_sel);
    end

    // Decode of the states that act on the registers.
    always_comb begin
        in_reset = (state == ST_RESET);
        cap_dr   = (state == ST_DCAP);
        shf_dr   = (state == ST_DSHF);
        upd_dr   = (state == ST_DUPD);
        cap_ir   = (state == ST_ICAP);
        shf_ir   = (state == ST_ISHF);
        upd_ir   = (state == ST_IUPD);
    end

endmodule

// File: rtl/scan_ir.sv
// Instruction register: a shift stage on the rising edge and an active
// stage loaded on the falling edge of the update state. Reset, either
// asynchronous or the controller reset state, selects all ones.
// Assumes IR_W >= 2.
module scan_ir #(
    parameter int IR_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic            shf_en,
    input  logic            upd_en,
    input  logic            in_reset,
    input  logic            ser_in,
    output logic            ir_lsb,
    output logic [IR_W-1:0] active
);

    localparam logic [IR_W-1:0] CAPT_PAT = IR_W'(1);

    logic [IR_W-1:0] shreg;

    // Shift stage: fixed pattern on capture, serial shift toward bit 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shreg <= CAPT_PAT;
        else if (cap_en) shreg <= CAPT_PAT;
        else if (shf_en) shreg <= {ser_in, shreg[IR_W-1:1]};
    end

    // Active stage: loads the shifted code, forced to bypass in reset.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)        active <= '1;
        else if (in_reset) active <= '1;
        else if (upd_en)   active <= shreg;
    end

    assign ir_lsb = shreg[0];

endmodule

// File: rtl/scan_cell.sv
// One boundary cell: a capture/shift flop on the rising edge and an
// update latch on the falling edge. The output is the functional input
// in functional mode and the update latch in test mode.
module scan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shf_en,
    input  logic upd_en,
    input  logic test_mode,
    input  logic func_in,
    input  logic scan_in,
    output logic cap_q,
    output logic upd_q,
    output logic func_out
);

    // Capture/shift flop: functional input on capture, neighbour on shift.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cap_q <= 1'b0;
        else if (cap_en) cap_q <= func_in;
        else if (shf_en) cap_q <= scan_in;
    end

    // Update latch: copies the capture flop in the update state.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)      upd_q <= 1'b0;
        else if (upd_en) upd_q <= cap_q;
    end

    // Output mux between pass-through and test data.
    assign func_out = test_mode ? upd_q : func_in;

endmodule

// File: rtl/scan_chain.sv
// Serial chain of NCELLS boundary cells. Serial input enters the top cell;
// cell 0 is nearest the serial output. All cells share the strobes.
module scan_chain #(
    parameter int NCELLS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              shf_en,
    input  logic              upd_en,
    input  logic              test_mode,
    input  logic              ser_in,
    input  logic [NCELLS-1:0] pin_in,
    output logic [NCELLS-1:0] cap_vec,
    output logic [NCELLS-1:0] upd_vec,
    output logic [NCELLS-1:0] pin_out,
    output logic              chain_lsb
);

    logic [NCELLS-1:0] scan_src;

    // Each cell shifts from its upper neighbour; the top one from ser_in.
    if (NCELLS > 1) begin : g_multi
        assign scan_src = {ser_in, cap_vec[NCELLS-1:1]};
    end else begin : g_single
        assign scan_src = ser_in;
    end

    for (genvar k = 0; k < NCELLS; k++) begin : g_cell
        scan_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (cap_en),
            .shf_en   (shf_en),
            .upd_en   (upd_en),
            .test_mode(test_mode),
            .func_in  (pin_in[k]),
            .scan_in  (scan_src[k]),
            .cap_q    (cap_vec[k]),
            .upd_q    (upd_vec[k]),
            .func_out (pin_out[k])
        );
    end

    assign chain_lsb = cap_vec[0];

endmodule

// File: rtl/scan_port_top.sv
// Serial test port top: controller, instruction register, bypass stage,
// boundary chain and the falling-edge serial output stage.
// Codes: 0 drive, 1 observe, any other code bypass (reset gives all ones).
module scan_port_top
    import scan_pkg::*;
#(
    parameter int NCELLS = 4,
    parameter int IR_W   = 2
) (
    input  logic              test_clk,
    input  logic              test_rst_n,
    input  logic              mode_sel,
    input  logic              ser_in,
    input  logic [NCELLS-1:0] pin_in,
    output logic              ser_out,
    output logic              ser_oe,
    output logic [NCELLS-1:0] pin_out
);

    localparam logic [IR_W-1:0] CODE_DRIVE   = '0;
    localparam logic [IR_W-1:0] CODE_OBSERVE = IR_W'(1);

    tap_state_e        st;
    logic              in_reset, cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir;
    logic              ir_lsb;
    logic [IR_W-1:0]   ir_active;
    logic              bnd_sel, test_mode;
    logic              byp_q;
    logic [NCELLS-1:0] cap_vec, upd_vec;
    logic              chain_lsb;
    logic              out_src;

    scan_fsm u_fsm (
        .clk     (test_clk),
        .rst_n   (test_rst_n),
        .mode_sel(mode_sel),
        .state   (st),
        .in_reset(in_reset),
        .cap_dr  (cap_dr),
        .shf_dr  (shf_dr),
        .upd_dr  (upd_dr),
        .cap_ir  (cap_ir),
        .shf_ir  (shf_ir),
        .upd_ir  (upd_ir)
    );

    scan_ir #(.IR_W(IR_W)) u_ir (
        .clk     (test_clk),
        .rst_n   (test_rst_n),
        .cap_en  (cap_ir),
        .shf_en  (shf_ir),
        .upd_en  (upd_ir),
        .in_reset(in_reset),
        .ser_in  (ser_in),
        .ir_lsb  (ir_lsb),
        .active  (ir_active)
    );

    // Instruction decode: which data path, and whether pins are driven.
    always_comb begin
        test_mode = (ir_active == CODE_DRIVE);
        bnd_sel   = test_mode || (ir_active == CODE_OBSERVE);
    end

    // One-bit bypass stage: zero on capture, serial input on shift.
    always_ff @(posedge test_clk or negedge test_rst_n) begin
        if (!test_rst_n)           byp_q <= 1'b0;
        else if (cap_dr && !bnd_sel) byp_q <= 1'b0;
        else if (shf_dr && !bnd_sel) byp_q <= ser_in;
    end

    scan_chain #(.NCELLS(NCELLS)) u_chain (
        .clk      (test_clk),
        .rst_n    (test_rst_n),
        .cap_en   (cap_dr && bnd_sel),
        .shf_en   (shf_dr && bnd_sel),
        .upd_en   (upd_dr && bnd_sel),
        .test_mode(test_mode),
        .ser_in   (ser_in),
        .pin_in   (pin_in),
        .cap_vec  (cap_vec),
        .upd_vec  (upd_vec),
        .pin_out  (pin_out),
        .chain_lsb(chain_lsb)
    );

    // Serial output source for the current shift state.
    always_comb begin
        if (shf_ir)       out_src = ir_lsb;
        else if (bnd_sel) out_src = chain_lsb;
        else              out_src = byp_q;
    end

    // Falling-edge output stage: drive only while shifting.
    always_ff @(negedge test_clk or negedge test_rst_n) begin
        if (!test_rst_n) begin
            ser_out <= 1'b0;
            ser_oe  <= 1'b0;
        end else if (shf_dr || shf_ir) begin
            ser_out <= out_src;
            ser_oe  <= 1'b1;
        end else begin
            ser_out <= 1'b0;
            ser_oe  <= 1'b0;
        end
    end

endmodule

// File: rtl/scan_port_chk.sv
// Property checker for the serial test port, bound into the top module.
// Observes the controller state, instruction, chain and output stage.
module scan_port_chk
    import scan_pkg::*;
#(
    parameter int NCELLS = 4,
    parameter int IR_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_sel,
    input logic              ser_in,
    input tap_state_e        state,
    input logic [IR_W-1:0]   ir_active,
    input logic              bnd_sel,
    input logic [NCELLS-1:0] cap_vec,
    input logic [NCELLS-1:0] upd_vec,
    input logic [NCELLS-1:0] pin_in,
    input logic              ser_out,
    input logic              ser_oe
);

    logic [2:0] ones_cnt;

    // Counts consecutive high mode bits, saturating at five.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ones_cnt <= '0;
        else if (!mode_sel) ones_cnt <= '0;
        else if (ones_cnt < 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_cnt == 3'd5) |-> (state == ST_RESET)); // R2

    AST_RESET_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET) |-> (ir_active == '1)); // R3

    AST_CAPTURE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DCAP && bnd_sel) |=> (cap_vec == $past(pin_in))); // R6

    AST_SHIFT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DSHF && bnd_sel) |=> (cap_vec[NCELLS-1] == $past(ser_in))); // R7

    AST_LATCH_ONLY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(upd_vec) |-> (state == ST_DUPD)); // R8

    AST_OE_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        ser_oe |-> (state == ST_DSHF || state == ST_ISHF)); // R10

    AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe |-> !ser_out); // R10

endmodule

bind scan_port_top scan_port_chk #(.NCELLS(NCELLS), .IR_W(IR_W)) u_chk (
    .clk      (test_clk),
    .rst_n    (test_rst_n),
    .mode_sel (mode_sel),
    .ser_in   (ser_in),
    .state    (st),
    .ir_active(ir_active),
    .bnd_sel  (bnd_sel),
    .cap_vec  (cap_vec),
    .upd_vec  (upd_vec),
    .pin_in   (pin_in),
    .ser_out  (ser_out),
    .ser_oe   (ser_oe)
);

// File: tb/scan_port_top_bench.sv
// Bench: inputs set 2 ns after a falling edge, outputs sampled there.
module scan_port_top_bench;

    localparam int N   = 4;
    localparam int IRW = 2;

    logic          test_clk   = 1'b0;
    logic          test_rst_n = 1'b0;
    logic          mode_sel   = 1'b1;
    logic          ser_in     = 1'b0;
    logic [N-1:0]  pin_in     = '0;
    logic          ser_out, ser_oe;
    logic [N-1:0]  pin_out;

    int errs   = 0;
    int checks = 0;

    always #10 test_clk = ~test_clk;

    scan_port_top #(.NCELLS(N), .IR_W(IRW)) u_scan_port_top (
        .test_clk  (test_clk),
        .test_rst_n(test_rst_n),
        .mode_sel  (mode_sel),
        .ser_in    (ser_in),
        .pin_in    (pin_in),
        .ser_out   (ser_out),
        .ser_oe    (ser_oe),
        .pin_out   (pin_out)
    );

    // Row: code[17:16] pins[15:12] sdata[11:8] expected capture[7:4] expected pins[3:0]
    localparam logic [17:0] VECS [5] = '{
        {2'd1, 4'b1010, 4'b0011, 4'b1010, 4'b1010},
        {2'd0, 4'b0110, 4'b1100, 4'b0110, 4'b1100},
        {2'd0, 4'b1111, 4'b0101, 4'b1111, 4'b0101},
        {2'd3, 4'b1001, 4'b1011, 4'b0110, 4'b1001},
        {2'd2, 4'b0001, 4'b0111, 4'b1110, 4'b0001}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        mode_sel = m;
        ser_in   = d;
        @(posedge test_clk);
        @(negedge test_clk);
        #2;
    endtask

    // From idle: load an instruction, return the captured pattern, end in idle.
    task automatic shift_ir(input logic [IRW-1:0] code, output logic [IRW-1:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        cap[0] = ser_out;
        for (int i = 0; i < IRW; i++) begin
            tick(i == IRW - 1, code[i]);
            if (i < IRW - 1) cap[i+1] = ser_out;
        end
        tick(1, 0); tick(0, 0);
    endtask

    // From idle: scan N data bits, return the bits seen, end in idle.
    task automatic shift_dr(input logic [N-1:0] data, output logic [N-1:0] cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        cap[0] = ser_out;
        for (int i = 0; i < N; i++) begin
            tick(i == N - 1, data[i]);
            if (i < N - 1) cap[i+1] = ser_out;
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        #4_000_000;
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [IRW-1:0] ircap;
        logic [N-1:0]   dcap;
        pin_in = 4'b1100;
        @(negedge test_clk);
        #2;
        chk("R1 reset oe", {7'd0, ser_oe}, 8'd0);
        chk("R1 reset out", {7'd0, ser_out}, 8'd0);
        chk("R9 reset transparent", {4'd0, pin_out}, {4'd0, pin_in});
        test_rst_n = 1'b1;
        tick(0, 0);

        for (int r = 0; r < 5; r++) begin
            shift_ir(VECS[r][17:16], ircap);
            chk("R3 ir capture pattern", {6'd0, ircap}, 8'd1);
            pin_in = VECS[r][15:12];
            shift_dr(VECS[r][11:8], dcap);
            chk("R4 R5 R6 R7 scan bits", {4'd0, dcap}, {4'd0, VECS[r][7:4]});
            chk("R8 R9 pins after update", {4'd0, pin_out}, {4'd0, VECS[r][3:0]});
        end

        // R8: bypass scans left the latch from the last drive row.
        shift_ir(2'd0, ircap);
        chk("R8 latch held over bypass", {4'd0, pin_out}, 8'b0101);

        // R10: output moves on the falling edge only.
        pin_in = 4'b0110;
        tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R10 first bit", {6'd0, ser_oe, ser_out}, 8'b10);
        mode_sel = 0;
        ser_in   = 0;
        @(posedge test_clk);
        #2;
        chk("R10 held until fall", {7'd0, ser_out}, 8'd0);
        @(negedge test_clk);
        #2;
        chk("R10 after fall", {7'd0, ser_out}, 8'd1);
        tick(1, 0);
        chk("R10 idle outside shift", {6'd0, ser_oe, ser_out}, 8'd0);
        tick(0, 0); tick(1, 0); tick(0, 0);
        chk("R2 resume after pause", {6'd0, ser_oe, ser_out}, 8'b11);
        tick(0, 0);
        // R2: five high bits from data shift reach reset, code back to bypass.
        for (int i = 0; i < 5; i++) tick(1, 0);
        chk("R2 R3 reset from data shift", {4'd0, pin_out}, {4'd0, pin_in});
        tick(0, 0);

        // R2: five high bits from instruction shift.
        shift_ir(2'd0, ircap);
        pin_in = 4'b1001;
        chk("R9 drive shows latch", {4'd0, pin_out}, 8'd0);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(1, 0);
        chk("R2 reset from instruction shift", {4'd0, pin_out}, 8'b1001);
        tick(0, 0);

        // R1: asynchronous reset mid-cycle during a drive-mode shift.
        shift_ir(2'd0, ircap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R10 oe in shift", {7'd0, ser_oe}, 8'd1);
        #3;
        test_rst_n = 1'b0;
        #1;
        chk("R1 async oe", {7'd0, ser_oe}, 8'd0);
        chk("R1 async pins", {4'd0, pin_out}, 8'b1001);
        @(negedge test_clk);
        #2;
        test_rst_n = 1'b1;
        tick(0, 0);
        shift_dr(4'b1111, dcap);
        chk("R1 R5 bypass after reset", {4'd0, dcap}, 8'b1110);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule